// File: doc/BRIEF.md
# Supply Domain Isolation Sequencer

This block brings up three supply domains that may be powered separately from the main supply: a USB transceiver supply, a secondary I/O bank supply and an analog supply. Each domain sits behind a power isolation barrier. The barrier must not be opened until the domain's supply has been shown to be good.

When a domain's request is raised and its strap says the supply is independent, the sequencer takes four steps. It switches on the domain's voltage monitor and waits a per-domain number of wakeup cycles. It then polls the monitor's "below threshold" flag until the flag clears. Finally it releases isolation. The poll is bounded by a timeout. If the timeout expires, the domain stays isolated and its error flag is raised. A domain whose strap says it shares the main supply skips the monitor steps entirely.

The USB and I/O domains are released through dedicated release outputs. The analog domain is released by an analog-peripheral enable output, which removes that domain's isolation as a side effect. The analog domain can be checked with either of two monitors. Domains are served one at a time, in fixed priority order.

Top module: `supply_iso_seq`

## Requirements
- R1: While reset is applied, and right after it is released, every release output is 0 (isolated), every monitor enable is 0, the done and error flags are 0 and busy is 0.
- R2: Domains are served one at a time in fixed priority order: index 0 is USB, index 1 is I/O, index 2 is analog, and the lowest pending index wins. If all three requests are raised at once and none is independent, done bits 0, 1 and 2 set 2, 4 and 6 cycles after the first clock edge that sees the requests.
- R3: For a domain whose independent strap is 0, no monitor enable is raised. Its done flag and release output set 2 cycles after the clock edge that first sees the request.
- R4: For an independent domain, the monitor enable stays high for exactly the domain's wakeup count (WAKE_USB, WAKE_IO or WAKE_ANA cycles) before the monitor flag is sampled. The flag's value during that window has no effect. With the flag already clear, done and release set WAKE+3 edges after the request is first seen.
- R5: After the wakeup window, the sequencer waits while the monitor flag (mon_low_i bit, 1 = below threshold) stays high. Release and done follow 2 edges after the first edge that sees the flag low.
- R6: If the flag is still high after TMO poll cycles, the domain's error flag sets at edge WAKE+TMO+1. Its monitor enable drops, and its release output and done flag stay 0.
- R7: When the domain's bit of mon_keep_i is 0, the monitor enable drops when isolation is released. When it is 1, the enable stays high after release.
- R8: The analog domain uses monitor index 2 (mon_en_o[2] / mon_low_i[2]) when ana_mon_sel_i is 0 and monitor index 3 when it is 1. Index 0 serves USB and index 1 serves I/O.
- R9: USB and I/O isolation are released on iso_rel_o[0] and iso_rel_o[1]. The analog domain is released by raising ana_periph_en_o.
- R10: Release outputs and done/error flags only ever go from 0 to 1 until the next reset. A domain that is done or in error is not served again, and an errored domain does not block the lower-priority domains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 3 | Per-domain bring-up request (0 USB, 1 I/O, 2 analog) |
| indep_i | input | 3 | Strap: domain supply is independent of the main supply |
| mon_keep_i | input | 3 | Keep the domain's monitor enabled after release |
| ana_mon_sel_i | input | 1 | Analog monitor choice: 0 uses monitor 2, 1 uses monitor 3 |
| mon_low_i | input | 4 | Monitor outputs, 1 = supply below threshold |
| mon_en_o | output | 4 | Monitor enables |
| iso_rel_o | output | 2 | Isolation release for USB (bit 0) and I/O (bit 1) |
| ana_periph_en_o | output | 1 | Analog peripheral enable, which releases analog isolation |
| done_o | output | 3 | Per-domain bring-up completed |
| err_o | output | 3 | Per-domain monitor timeout |
| busy_o | output | 1 | A sequence is in progress |

## Verification
The bench measures the exact latency from request to done. A design that sampled the monitor during the wakeup window, or that miscounted the window by one, finishes a cycle early or late and is caught. One test leaves the USB monitor low forever and checks that the error lands on the cycle the timeout sets. That test also checks that isolation stays closed and that the I/O request behind it is still served, so an error that released the domain or hung the arbiter would show. In the analog test the unselected monitor is held low while the selected one clears, so a design that polled the wrong monitor would time out. Other tests raise all three requests together to expose wrong ordering, and check monitor enables after release against the keep input.

// File: rtl/supseq_pkg.sv
package supseq_pkg;

  localparam int NDOM = 3;
  localparam int NMON = 4;

  typedef logic [1:0] dom_idx_t;
  typedef logic [1:0] mon_idx_t;

  localparam dom_idx_t DOM_USB = 2'd0;
  localparam dom_idx_t DOM_IO  = 2'd1;
  localparam dom_idx_t DOM_ANA = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAKE = 2'd1,
    ST_POLL = 2'd2,
    ST_REL  = 2'd3
  } seq_st_e;

  // The analog domain may be watched by either of two monitors.
  function automatic mon_idx_t mon_of(dom_idx_t d, logic alt);
    if (d == DOM_ANA) return alt ? 2'd3 : 2'd2;
    return mon_idx_t'(d);
  endfunction

endpackage

// File: rtl/supseq_rst_sync.sv
module supseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/supseq_arbiter.sv
module supseq_arbiter #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);

  logic [N-1:0] lower_mask;

  // Lowest index wins: scan from the top so the last hit is the lowest.
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IW'(i);
    end
  end

  assign vld_o      = |pend_i;
  assign lower_mask = (N'(1) << idx_o) - N'(1);

  AST_GRANT_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> pend_i[idx_o]);                                   // R2
  AST_GRANT_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> ((pend_i & lower_mask) == '0));                   // R2

endmodule

// File: rtl/supseq_dncnt.sv
module supseq_dncnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i | (dec_i & (cnt_q != '0));
    cnt_d  = load_i ? val_i : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i && zero_o) |=> zero_o);                   // R4

endmodule

// File: rtl/supseq_fsm.sv
module supseq_fsm
  import supseq_pkg::*;
#(
  parameter int WAKE_USB = 4,
  parameter int WAKE_IO  = 6,
  parameter int WAKE_ANA = 8,
  parameter int TMO      = 16,
  parameter int CW       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gnt_vld_i,
  input  dom_idx_t         gnt_idx_i,
  input  logic [NDOM-1:0]  indep_i,
  input  logic [NDOM-1:0]  keep_i,
  input  logic             ana_sel_i,
  input  logic [NMON-1:0]  mon_low_i,
  input  logic             cnt_zero_i,
  output logic             cnt_load_o,
  output logic [CW-1:0]    cnt_val_o,
  output logic             cnt_dec_o,
  output logic [NMON-1:0]  mon_en_o,
  output logic [NDOM-1:0]  rel_o,
  output logic [NDOM-1:0]  done_o,
  output logic [NDOM-1:0]  err_o,
  output logic             busy_o
);

  seq_st_e         state_q, state_d;
  dom_idx_t        cur_q, cur_d;
  logic            alt_q, alt_d;
  logic [NMON-1:0] mon_q, mon_d;
  logic [NDOM-1:0] rel_q, rel_d;
  logic [NDOM-1:0] done_q, done_d;
  logic [NDOM-1:0] err_q, err_d;
  logic            ctl_en;
  mon_idx_t        mon_cur;

  function automatic logic [CW-1:0] wake_load(dom_idx_t d);
    case (d)
      DOM_USB: return CW'(WAKE_USB - 1);
      DOM_IO:  return CW'(WAKE_IO - 1);
      default: return CW'(WAKE_ANA - 1);
    endcase
  endfunction

  assign mon_cur = mon_of(cur_q, alt_q);

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    cur_d      = cur_q;
    alt_d      = alt_q;
    mon_d      = mon_q;
    rel_d      = rel_q;
    done_d     = done_q;
    err_d      = err_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    cnt_dec_o  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (gnt_vld_i) begin
          cur_d = gnt_idx_i;
          alt_d = ana_sel_i;
          if (indep_i[gnt_idx_i]) begin
            state_d    = ST_WAKE;
            mon_d[mon_of(gnt_idx_i, ana_sel_i)] = 1'b1;
            cnt_load_o = 1'b1;
            cnt_val_o  = wake_load(gnt_idx_i);
          end else begin
            state_d = ST_REL;
          end
        end
      end
      ST_WAKE: begin
        cnt_dec_o = 1'b1;
        if (cnt_zero_i) begin
          state_d    = ST_POLL;
          cnt_load_o = 1'b1;
          cnt_val_o  = CW'(TMO - 1);
        end
      end
      ST_POLL: begin
        if (!mon_low_i[mon_cur]) begin
          state_d = ST_REL;
          if (!keep_i[cur_q]) mon_d[mon_cur] = 1'b0;
        end else if (cnt_zero_i) begin
          state_d        = ST_IDLE;
          err_d[cur_q]   = 1'b1;
          mon_d[mon_cur] = 1'b0;
        end else begin
          cnt_dec_o = 1'b1;
        end
      end
      default: begin
        rel_d[cur_q]  = 1'b1;
        done_d[cur_q] = 1'b1;
        state_d       = ST_IDLE;
      end
    endcase
  end

  assign ctl_en = (state_q != ST_IDLE) | gnt_vld_i;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= DOM_USB;
      alt_q   <= 1'b0;
      mon_q   <= '0;
      rel_q   <= '0;
      done_q  <= '0;
      err_q   <= '0;
    end else if (ctl_en) begin
      state_q <= state_d;
      cur_q   <= cur_d;
      alt_q   <= alt_d;
      mon_q   <= mon_d;
      rel_q   <= rel_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign mon_en_o = mon_q;
  assign rel_o    = rel_q;
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign busy_o   = (state_q != ST_IDLE);

  AST_WAKE_MON_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE) |-> mon_q[mon_cur]);                   // R4
  AST_POLL_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POLL && $past(state_q) == ST_WAKE) |-> $past(cnt_zero_i)); // R4
  AST_SHARED_NO_MON: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REL && $past(state_q) == ST_IDLE) |-> $stable(mon_q)); // R3
  AST_ERR_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q & rel_q) == '0);                                     // R6
  AST_REL_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    ((rel_q & $past(rel_q)) == $past(rel_q)));                  // R10
  AST_FLAGS_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    (((done_q | err_q) & $past(done_q | err_q)) == $past(done_q | err_q))); // R10

endmodule

// File: rtl/supply_iso_seq.sv
module supply_iso_seq
  import supseq_pkg::*;
#(
  parameter int WAKE_USB = 4,
  parameter int WAKE_IO  = 6,
  parameter int WAKE_ANA = 8,
  parameter int TMO      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] req_i,
  input  logic [2:0] indep_i,
  input  logic [2:0] mon_keep_i,
  input  logic       ana_mon_sel_i,
  input  logic [3:0] mon_low_i,
  output logic [3:0] mon_en_o,
  output logic [1:0] iso_rel_o,
  output logic       ana_periph_en_o,
  output logic [2:0] done_o,
  output logic [2:0] err_o,
  output logic       busy_o
);

  localparam int MAXW1 = (WAKE_USB > WAKE_IO) ? WAKE_USB : WAKE_IO;
  localparam int MAXW2 = (MAXW1 > WAKE_ANA) ? MAXW1 : WAKE_ANA;
  localparam int MAXC  = (MAXW2 > TMO) ? MAXW2 : TMO;
  localparam int CW    = $clog2(MAXC + 1);

  logic            rst_sync_n;
  logic [NDOM-1:0] pend;
  logic            gnt_vld;
  dom_idx_t        gnt_idx;
  logic            cnt_load;
  logic [CW-1:0]   cnt_val;
  logic            cnt_dec;
  logic            cnt_zero;
  logic [NDOM-1:0] rel;
  logic [NDOM-1:0] done;
  logic [NDOM-1:0] err;

  supseq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign pend = req_i & ~done & ~err;

  supseq_arbiter #(.N(NDOM), .IW(2)) u_arb (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pend_i (pend),
    .vld_o  (gnt_vld),
    .idx_o  (gnt_idx)
  );

  supseq_dncnt #(.W(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .dec_i  (cnt_dec),
    .zero_o (cnt_zero)
  );

  supseq_fsm #(
    .WAKE_USB (WAKE_USB),
    .WAKE_IO  (WAKE_IO),
    .WAKE_ANA (WAKE_ANA),
    .TMO      (TMO),
    .CW       (CW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .gnt_vld_i  (gnt_vld),
    .gnt_idx_i  (gnt_idx),
    .indep_i    (indep_i),
    .keep_i     (mon_keep_i),
    .ana_sel_i  (ana_mon_sel_i),
    .mon_low_i  (mon_low_i),
    .cnt_zero_i (cnt_zero),
    .cnt_load_o (cnt_load),
    .cnt_val_o  (cnt_val),
    .cnt_dec_o  (cnt_dec),
    .mon_en_o   (mon_en_o),
    .rel_o      (rel),
    .done_o     (done),
    .err_o      (err),
    .busy_o     (busy_o)
  );

  assign iso_rel_o       = rel[1:0];
  assign ana_periph_en_o = rel[DOM_ANA];
  assign done_o          = done;
  assign err_o           = err;

  AST_NO_DONE_AND_ERR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o & err_o) == '0);                                    // R6

endmodule

// File: tb/supply_iso_seq_tb.sv
module supply_iso_seq_tb;

  localparam int W_USB = 4;
  localparam int W_IO  = 6;
  localparam int W_ANA = 8;
  localparam int T_OUT = 16;

  logic       clk;
  logic       rst_n;
  logic [2:0] req_i;
  logic [2:0] indep_i;
  logic [2:0] mon_keep_i;
  logic       ana_mon_sel_i;
  logic [3:0] mon_low_i;
  logic [3:0] mon_en_o;
  logic [1:0] iso_rel_o;
  logic       ana_periph_en_o;
  logic [2:0] done_o;
  logic [2:0] err_o;
  logic       busy_o;

  int         n_tests = 0;
  int         n_fail  = 0;
  bit         finished = 0;
  logic [3:0] seen_mon;

  supply_iso_seq #(
    .WAKE_USB (W_USB),
    .WAKE_IO  (W_IO),
    .WAKE_ANA (W_ANA),
    .TMO      (T_OUT)
  ) u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_i           (req_i),
    .indep_i         (indep_i),
    .mon_keep_i      (mon_keep_i),
    .ana_mon_sel_i   (ana_mon_sel_i),
    .mon_low_i       (mon_low_i),
    .mon_en_o        (mon_en_o),
    .iso_rel_o       (iso_rel_o),
    .ana_periph_en_o (ana_periph_en_o),
    .done_o          (done_o),
    .err_o           (err_o),
    .busy_o          (busy_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) seen_mon = seen_mon | mon_en_o;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n         = 1'b0;
    req_i         = '0;
    indep_i       = '0;
    mon_keep_i    = '0;
    ana_mon_sel_i = 1'b0;
    mon_low_i     = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    seen_mon = '0;
  endtask

  // Counts edges until done or err shows; clears monitor bits after edge clr_at.
  task automatic run(input int clr_at, input logic [3:0] clr_mask, output int n);
    n = 0;
    for (int k = 1; k <= 100; k++) begin
      @(posedge clk);
      #1;
      n = k;
      if ((done_o | err_o) != 3'b000) break;
      if (k == clr_at) mon_low_i = mon_low_i & ~clr_mask;
    end
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 iso_rel", 32'(iso_rel_o), 32'h0);
    chk("R1 ana_en", 32'(ana_periph_en_o), 32'h0);
    chk("R1 mon_en", 32'(mon_en_o), 32'h0);
    chk("R1 done", 32'(done_o), 32'h0);
    chk("R1 err", 32'(err_o), 32'h0);
    chk("R1 busy", 32'(busy_o), 32'h0);
  endtask

  task automatic t_shared_usb();
    int n;
    do_reset();
    @(negedge clk);
    req_i = 3'b001;
    mon_low_i = 4'hF;
    run(0, 4'h0, n);
    chk("R3 latency", 32'(n), 32'd2);
    chk("R3 no monitor", 32'(seen_mon), 32'h0);
    chk("R9 usb release", 32'(iso_rel_o), 32'h1);
    chk("R3 done", 32'(done_o), 32'h1);
  endtask

  task automatic t_indep_io();
    int n;
    do_reset();
    @(negedge clk);
    indep_i = 3'b010;
    req_i   = 3'b010;
    run(0, 4'h0, n);
    chk("R4 wake latency", 32'(n), 32'(W_IO + 3));
    chk("R9 io release", 32'(iso_rel_o), 32'h2);
    chk("R4 monitor used", 32'(seen_mon), 32'h2);
    chk("R7 monitor off", 32'(mon_en_o), 32'h0);
  endtask

  task automatic t_analog_alt();
    int n;
    do_reset();
    @(negedge clk);
    indep_i       = 3'b100;
    mon_keep_i    = 3'b100;
    ana_mon_sel_i = 1'b1;
    mon_low_i     = 4'b1100;
    req_i         = 3'b100;
    run(12, 4'b1000, n);
    chk("R5 clear latency", 32'(n), 32'd14);
    chk("R8 alt monitor only", 32'(seen_mon), 32'h8);
    chk("R7 monitor kept", 32'(mon_en_o), 32'h8);
    chk("R9 analog enable", 32'(ana_periph_en_o), 32'h1);
    chk("R9 no iso bits", 32'(iso_rel_o), 32'h0);
  endtask

  task automatic t_timeout();
    int n;
    do_reset();
    @(negedge clk);
    indep_i   = 3'b001;
    mon_low_i = 4'b0001;
    req_i     = 3'b011;
    run(0, 4'h0, n);
    chk("R6 timeout latency", 32'(n), 32'(W_USB + T_OUT + 1));
    chk("R6 err flag", 32'(err_o), 32'h1);
    chk("R6 still isolated", 32'(iso_rel_o), 32'h0);
    chk("R6 monitor off", 32'(mon_en_o), 32'h0);
    repeat (2) @(posedge clk);
    #1;
    chk("R10 io served after err", 32'(done_o), 32'h2);
    chk("R10 err sticky", 32'(err_o), 32'h1);
    repeat (4) @(posedge clk);
    #1;
    chk("R10 usb not retried", 32'(busy_o), 32'h0);
  endtask

  task automatic t_priority();
    int n;
    do_reset();
    @(negedge clk);
    req_i = 3'b111;
    run(0, 4'h0, n);
    chk("R2 first edge", 32'(n), 32'd2);
    chk("R2 usb first", 32'(done_o), 32'h1);
    @(posedge clk); #1;
    chk("R2 one at a time", 32'(done_o), 32'h1);
    @(posedge clk); #1;
    chk("R2 io second", 32'(done_o), 32'h3);
    repeat (2) @(posedge clk); #1;
    chk("R2 analog third", 32'(done_o), 32'h7);
    chk("R9 all released", 32'({ana_periph_en_o, iso_rel_o}), 32'h7);
    req_i = 3'b000;
    repeat (2) @(posedge clk); #1;
    chk("R10 release holds", 32'({ana_periph_en_o, iso_rel_o}), 32'h7);
  endtask

  initial begin
    t_reset();
    t_shared_usb();
    t_indep_io();
    t_analog_alt();
    t_timeout();
    t_priority();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule